// File: doc/BRIEF.md
# Cache-Line Reservation Monitor for Load-Linked / Store-Conditional

This block keeps the reservation state that load-linked / store-conditional pairs rely on, inside a set-associative data cache. Each way of each set holds a small owner register naming the hardware context that currently holds a reservation on the line in that way. The block keeps its own copy of the line tags, updated from the cache's allocate and deallocate events, so that it can find the way a request refers to without touching the real tag array.

A core presents one request per cycle: plain loads and stores, locked reads and locked writes, and read-modify-write reads and writes. Each request is answered one cycle later with a status and, when it goes ahead, an issue strobe carrying the request type the cache controller should use. A locked read reserves the line for its context when its completion comes back. A locked write goes ahead only when the requesting context still owns the line; the check and the clear happen in a single cycle, so no other request can come between them. A failed conditional store leaves any existing reservation alone. Any allocate, deallocate or permission change on a line drops its reservation. Write-class requests are tracked per line so that at most one is outstanding per line, and requests that run past the end of a line are refused.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no way has an owner, no line is pending and all outputs are low; a locked write to a present line then fails.
- R2: Every request gets exactly one response strobe in the next cycle (resp_valid high for one cycle); when the status is done, iss_valid is high in that same cycle with iss_addr equal to the request address, otherwise iss_valid is low.
- R3: A completion with cmp_lock high, for a line present in the copy tags, makes cmp_ctx the owner of that way; a later locked write from that context returns status 2'b00 (done) and is issued.
- R4: A locked write that succeeds drops the reservation, so a second locked write from the same context (after the first is completed) returns status 2'b10.
- R5: A locked write whose context does not own the line returns status 2'b10 (the value -2 in two bits), is not issued, and leaves the reservation in place for its owner.
- R6: An allocate event (ev_kind 2'b00) into a way clears that way's owner.
- R7: A deallocate event (2'b01) or a permission-change event (2'b10) on a present line clears its owner; a deallocate also removes the line from the copy tags.
- R8: req_kind 3'd0 (load) is issued with iss_type 2'b00; store 3'd1, locked read 3'd2 and locked write 3'd3 with 2'b01; read-modify-write read 3'd4 and write 3'd5 with 2'b10.
- R9: Request kinds 1 to 5 claim a pending entry for their line when issued; another such request to that line, or any such request while all entries are taken, returns 2'b01 (busy) and is not issued; any completion frees its line's entry; loads never claim an entry and are never busy.
- R10: A request whose byte offset (low address bits) plus req_len exceeds the line size returns 2'b11, is not issued, claims no entry and neither checks nor clears a reservation.
- R11: A locked write that reaches the reservation check, or a reserving completion, for a line absent from the copy tags raises miss_err for one cycle, one cycle later; such a locked write fails with 2'b10.
- R12: When an allocate event and a reserving completion hit the same way in the same cycle, the way ends with no owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind (see R8) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | log2(LINE_BYTES)+1 | Access length in bytes |
| req_ctx | input | CTX_W | Requesting context; all-ones is reserved |
| cmp_valid | input | 1 | A tracked request has completed |
| cmp_lock | input | 1 | The completion belongs to a locked read and reserves the line |
| cmp_addr | input | ADDR_W | Address of the completed request |
| cmp_ctx | input | CTX_W | Context of the completed request |
| ev_valid | input | 1 | Cache line event present |
| ev_kind | input | 2 | 0 allocate, 1 deallocate, 2 permission change, 3 none |
| ev_addr | input | ADDR_W | Line address of the event |
| ev_way | input | log2(WAYS) | Target way of an allocate |
| resp_valid | output | 1 | Response strobe |
| resp_status | output | 2 | 0 done, 1 busy, 2 conditional-store fail, 3 crosses line |
| iss_valid | output | 1 | Request issued to the cache controller |
| iss_type | output | 2 | 0 load, 1 store, 2 atomic |
| iss_addr | output | ADDR_W | Address of the issued request |
| miss_err | output | 1 | Reservation operation on an absent line |

## Verification
The conditional store is tried from the owning context, from a foreign context, after its own success, and after each kind of line event, so that a stale reservation, a reservation that was wrongly cleared on failure and a missing event wipe each change a status value. Pending-line tracking is driven with repeated requests to one line, with the table filled by distinct lines and with loads mixed in, which separates per-line blocking from capacity blocking. Span tests put the access end exactly at the line boundary and one byte past it, and one same-cycle allocate-plus-reserve shows which update wins.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    RK_LOAD   = 3'd0,
    RK_STORE  = 3'd1,
    RK_LREAD  = 3'd2,
    RK_LWRITE = 3'd3,
    RK_RMWR   = 3'd4,
    RK_RMWW   = 3'd5,
    RK_RSV6   = 3'd6,
    RK_RSV7   = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    EK_ALLOC   = 2'd0,
    EK_DEALLOC = 2'd1,
    EK_PERM    = 2'd2,
    EK_NOP     = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    IT_LOAD   = 2'd0,
    IT_STORE  = 2'd1,
    IT_ATOMIC = 2'd2,
    IT_RSV    = 2'd3
  } iss_type_e;

  // Conditional-store failure is 2'b10, which reads as -2 in two bits.
  typedef enum logic [1:0] {
    RS_DONE   = 2'd0,
    RS_BUSY   = 2'd1,
    RS_SCFAIL = 2'd2,
    RS_SPAN   = 2'd3
  } resp_stat_e;

  typedef struct packed {
    resp_stat_e stat;
    logic       issue;
    iss_type_e  itype;
  } verdict_t;

  function automatic logic tracks_line(req_kind_e k);
    return k inside {RK_STORE, RK_LREAD, RK_LWRITE, RK_RMWR, RK_RMWW};
  endfunction

  function automatic iss_type_e kind_to_type(req_kind_e k);
    case (k)
      RK_STORE, RK_LREAD, RK_LWRITE: return IT_STORE;
      RK_RMWR, RK_RMWW:              return IT_ATOMIC;
      default:                       return IT_LOAD;
    endcase
  endfunction

endpackage

// File: rtl/llsc_tag_dir.sv
module llsc_tag_dir #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int NLOOK = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_vld,
  input  logic [SET_W-1:0] lk_set [NLOOK],
  input  logic [TAG_W-1:0] lk_tag [NLOOK],
  output logic             lk_hit [NLOOK],
  output logic [WAY_W-1:0] lk_way [NLOOK]
);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= wr_vld;
      if (wr_vld) tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  // One independent compare bank per lookup port.
  for (genvar p = 0; p < NLOOK; p++) begin : g_look
    logic             hit_l;
    logic [WAY_W-1:0] way_l;
    always_comb begin
      hit_l = 1'b0;
      way_l = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (vld_q[lk_set[p]][w] && (tag_q[lk_set[p]][w] == lk_tag[p])) begin
          hit_l = 1'b1;
          way_l = WAY_W'(w);
        end
      end
    end
    assign lk_hit[p] = hit_l;
    assign lk_way[p] = way_l;
  end

endmodule

// File: rtl/llsc_owner_array.sv
module llsc_owner_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int CTX_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_en,
  input  logic [SET_W-1:0] drop_set,
  input  logic [WAY_W-1:0] drop_way,
  input  logic             mark_en,
  input  logic [SET_W-1:0] mark_set,
  input  logic [WAY_W-1:0] mark_way,
  input  logic [CTX_W-1:0] mark_ctx,
  input  logic             wipe_en,
  input  logic [SET_W-1:0] wipe_set,
  input  logic [WAY_W-1:0] wipe_way,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic [CTX_W-1:0] rd_owner
);

  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  logic [CTX_W-1:0] own_q [SETS][WAYS];
  logic [CTX_W-1:0] own_d [SETS][WAYS];
  logic             upd;

  // Later statements win: line events beat a new reservation.
  always_comb begin
    own_d = own_q;
    if (drop_en) own_d[drop_set][drop_way] = NO_OWNER;
    if (mark_en) own_d[mark_set][mark_way] = mark_ctx;
    if (wipe_en) own_d[wipe_set][wipe_way] = NO_OWNER;
  end

  assign upd = drop_en | mark_en | wipe_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) own_q[s][w] <= NO_OWNER;
    end else if (upd) begin
      own_q <= own_d;
    end
  end

  assign rd_owner = own_q[rd_set][rd_way];

endmodule

// File: rtl/llsc_pend_table.sv
module llsc_pend_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] chk_line,
  output logic              chk_hit,
  output logic              full,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              free_en,
  input  logic [LINE_W-1:0] free_line
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [LINE_W-1:0] line_d [DEPTH];
  logic [IDX_W-1:0]  slot;
  logic              upd;

  always_comb begin
    chk_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && (line_q[i] == chk_line)) chk_hit = 1'b1;
  end

  assign full = &vld_q;

  // Lowest free entry.
  always_comb begin
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) slot = IDX_W'(i);
  end

  always_comb begin
    vld_d  = vld_q;
    line_d = line_q;
    if (free_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (vld_q[i] && (line_q[i] == free_line)) vld_d[i] = 1'b0;
    end
    if (ins_en && !full) begin
      vld_d[slot]  = 1'b1;
      line_d[slot] = ins_line;
    end
  end

  assign upd = ins_en | free_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else if (upd) begin
      vld_q  <= vld_d;
      line_q <= line_d;
    end
  end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int CTX_W      = 4,
  parameter int PEND_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [2:0]                    req_kind,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(LINE_BYTES):0]   req_len,
  input  logic [CTX_W-1:0]              req_ctx,
  input  logic                          cmp_valid,
  input  logic                          cmp_lock,
  input  logic [ADDR_W-1:0]             cmp_addr,
  input  logic [CTX_W-1:0]              cmp_ctx,
  input  logic                          ev_valid,
  input  logic [1:0]                    ev_kind,
  input  logic [ADDR_W-1:0]             ev_addr,
  input  logic [$clog2(WAYS)-1:0]       ev_way,
  output logic                          resp_valid,
  output logic [1:0]                    resp_status,
  output logic                          iss_valid,
  output logic [1:0]                    iss_type,
  output logic [ADDR_W-1:0]             iss_addr,
  output logic                          miss_err
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int LEN_W  = OFF_W + 1;
  localparam int NLOOK  = 3;
  localparam int LK_REQ = 0;
  localparam int LK_CMP = 1;
  localparam int LK_EV  = 2;
  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  // ---------------- address split for the three lookup ports
  logic [ADDR_W-1:0] lk_addr [NLOOK];
  logic [SET_W-1:0]  lk_set  [NLOOK];
  logic [TAG_W-1:0]  lk_tag  [NLOOK];
  logic              lk_hit  [NLOOK];
  logic [WAY_W-1:0]  lk_way  [NLOOK];

  assign lk_addr[LK_REQ] = req_addr;
  assign lk_addr[LK_CMP] = cmp_addr;
  assign lk_addr[LK_EV]  = ev_addr;

  for (genvar p = 0; p < NLOOK; p++) begin : g_split
    assign lk_set[p] = lk_addr[p][OFF_W +: SET_W];
    assign lk_tag[p] = lk_addr[p][ADDR_W-1 -: TAG_W];
  end

  // ---------------- line events
  ev_kind_e         ev_k;
  logic             dir_wr_en;
  logic             dir_wr_vld;
  logic [WAY_W-1:0] ev_tgt_way;
  logic             wipe_en;

  always_comb begin
    ev_k       = ev_kind_e'(ev_kind);
    dir_wr_vld = (ev_k == EK_ALLOC);
    ev_tgt_way = (ev_k == EK_ALLOC) ? ev_way : lk_way[LK_EV];
    dir_wr_en  = ev_valid &&
                 ((ev_k == EK_ALLOC) || ((ev_k == EK_DEALLOC) && lk_hit[LK_EV]));
    wipe_en    = ev_valid &&
                 ((ev_k == EK_ALLOC) ||
                  (((ev_k == EK_DEALLOC) || (ev_k == EK_PERM)) && lk_hit[LK_EV]));
  end

  llsc_tag_dir #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .NLOOK(NLOOK)
  ) u_tag_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (dir_wr_en),
    .wr_set(lk_set[LK_EV]),
    .wr_way(ev_tgt_way),
    .wr_tag(lk_tag[LK_EV]),
    .wr_vld(dir_wr_vld),
    .lk_set(lk_set),
    .lk_tag(lk_tag),
    .lk_hit(lk_hit),
    .lk_way(lk_way)
  );

  // ---------------- request decision
  req_kind_e        rq_k;
  logic [LEN_W:0]   span_end;
  logic             span_bad;
  logic             pend_hit;
  logic             pend_full;
  logic             busy;
  logic [CTX_W-1:0] rq_owner;
  logic             sc_match;
  logic             is_sc;
  verdict_t         vd;
  logic             req_miss;
  logic             cmp_miss;
  logic             drop_en;
  logic             mark_en;
  logic             ins_en;

  always_comb begin
    rq_k     = req_kind_e'(req_kind);
    is_sc    = (rq_k == RK_LWRITE);
    span_end = (LEN_W+1)'(req_addr[OFF_W-1:0]) + (LEN_W+1)'(req_len);
    span_bad = span_end > (LEN_W+1)'(LINE_BYTES);
    busy     = tracks_line(rq_k) && (pend_hit || pend_full);
    sc_match = lk_hit[LK_REQ] && (rq_owner != NO_OWNER) && (rq_owner == req_ctx);

    vd.itype = kind_to_type(rq_k);
    vd.issue = 1'b0;
    if (span_bad)               vd.stat = RS_SPAN;
    else if (busy)              vd.stat = RS_BUSY;
    else if (is_sc && !sc_match) vd.stat = RS_SCFAIL;
    else begin
      vd.stat  = RS_DONE;
      vd.issue = 1'b1;
    end

    req_miss = req_valid && is_sc && !span_bad && !busy && !lk_hit[LK_REQ];
    cmp_miss = cmp_valid && cmp_lock && !lk_hit[LK_CMP];
    drop_en  = req_valid && vd.issue && is_sc;
    ins_en   = req_valid && vd.issue && tracks_line(rq_k);
    mark_en  = cmp_valid && cmp_lock && lk_hit[LK_CMP];
  end

  llsc_owner_array #(
    .SETS (SETS),
    .WAYS (WAYS),
    .CTX_W(CTX_W)
  ) u_owner (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop_en (drop_en),
    .drop_set(lk_set[LK_REQ]),
    .drop_way(lk_way[LK_REQ]),
    .mark_en (mark_en),
    .mark_set(lk_set[LK_CMP]),
    .mark_way(lk_way[LK_CMP]),
    .mark_ctx(cmp_ctx),
    .wipe_en (wipe_en),
    .wipe_set(lk_set[LK_EV]),
    .wipe_way(ev_tgt_way),
    .rd_set  (lk_set[LK_REQ]),
    .rd_way  (lk_way[LK_REQ]),
    .rd_owner(rq_owner)
  );

  llsc_pend_table #(
    .DEPTH (PEND_DEPTH),
    .LINE_W(LINE_W)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_line (req_addr[ADDR_W-1:OFF_W]),
    .chk_hit  (pend_hit),
    .full     (pend_full),
    .ins_en   (ins_en),
    .ins_line (req_addr[ADDR_W-1:OFF_W]),
    .free_en  (cmp_valid),
    .free_line(cmp_addr[ADDR_W-1:OFF_W])
  );

  // ---------------- registered response
  logic              resp_valid_d, resp_valid_q;
  logic              iss_valid_d,  iss_valid_q;
  logic              err_d,        err_q;
  resp_stat_e        stat_q;
  iss_type_e         type_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    resp_valid_d = req_valid;
    iss_valid_d  = req_valid && vd.issue;
    err_d        = req_miss || cmp_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      iss_valid_q  <= 1'b0;
      err_q        <= 1'b0;
      stat_q       <= RS_DONE;
      type_q       <= IT_LOAD;
      addr_q       <= '0;
    end else begin
      resp_valid_q <= resp_valid_d;
      iss_valid_q  <= iss_valid_d;
      err_q        <= err_d;
      if (req_valid) begin
        stat_q <= vd.stat;
        type_q <= vd.itype;
        addr_q <= req_addr;
      end
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_status = stat_q;
  assign iss_valid   = iss_valid_q;
  assign iss_type    = type_q;
  assign iss_addr    = addr_q;
  assign miss_err    = err_q;

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [2:0]                  req_kind,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [$clog2(LINE_BYTES):0] req_len,
  input logic                        resp_valid,
  input logic [1:0]                  resp_status,
  input logic                        iss_valid,
  input logic [1:0]                  iss_type,
  input logic [ADDR_W-1:0]           iss_addr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W+1:0] end_byte;
  assign end_byte = (OFF_W+2)'(req_addr[OFF_W-1:0]) + (OFF_W+2)'(req_len);

  // R2
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R2
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R2
  iss_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (resp_valid && (resp_status == RS_DONE)));

  // R2
  iss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!iss_valid || (iss_addr == $past(req_addr))));

  // R5
  scfail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_status == RS_SCFAIL)) |-> !iss_valid);

  // R8
  locked_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_kind == RK_LREAD) || (req_kind == RK_LWRITE)))
      |=> (!iss_valid || (iss_type == IT_STORE)));

  // R8
  rmw_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_kind == RK_RMWR) || (req_kind == RK_RMWW)))
      |=> (!iss_valid || (iss_type == IT_ATOMIC)));

  // R10
  span_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (end_byte > (OFF_W+2)'(LINE_BYTES)))
      |=> ((resp_status == RS_SPAN) && !iss_valid));

  // R9
  load_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == RK_LOAD)) |=> (resp_status != RS_BUSY));

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .resp_valid (resp_valid),
  .resp_status(resp_status),
  .iss_valid  (iss_valid),
  .iss_type   (iss_type),
  .iss_addr   (iss_addr)
);

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;
  import llsc_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [6:0]  req_len;
  logic [3:0]  req_ctx;
  logic        cmp_valid;
  logic        cmp_lock;
  logic [15:0] cmp_addr;
  logic [3:0]  cmp_ctx;
  logic        ev_valid;
  logic [1:0]  ev_kind;
  logic [15:0] ev_addr;
  logic [1:0]  ev_way;
  logic        resp_valid;
  logic [1:0]  resp_status;
  logic        iss_valid;
  logic [1:0]  iss_type;
  logic [15:0] iss_addr;
  logic        miss_err;

  llsc_resv_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_ctx(req_ctx),
    .cmp_valid(cmp_valid), .cmp_lock(cmp_lock), .cmp_addr(cmp_addr), .cmp_ctx(cmp_ctx),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_way(ev_way),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .iss_valid(iss_valid), .iss_type(iss_type), .iss_addr(iss_addr),
    .miss_err(miss_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0]  stat;
    logic        iss;
    logic [1:0]  ityp;
    logic [15:0] addr;
    logic        err;
    string       rq;
    time         t;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Lines: A set 1 tag 2, B set 1 tag 3, C set 5 tag 1, X never allocated.
  localparam logic [15:0] LA = 16'h0840;
  localparam logic [15:0] LB = 16'h0C40;
  localparam logic [15:0] LC = 16'h0540;
  localparam logic [15:0] LX = 16'h7F00;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      chk("R2", "scoreboard drained", sbq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Expected issue type, per R8.
  function automatic logic [1:0] exp_type(input logic [2:0] k);
    if (k == RK_LOAD) return IT_LOAD;
    if (k == RK_RMWR || k == RK_RMWW) return IT_ATOMIC;
    return IT_STORE;
  endfunction

  // ---------------- driver
  task automatic do_req(input logic [2:0] k, input logic [15:0] a, input logic [6:0] l,
                        input logic [3:0] c, input logic [1:0] st, input logic err,
                        input string rq);
    exp_t e;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = l; req_ctx = c;
    e.stat = st; e.iss = (st == RS_DONE); e.ityp = exp_type(k); e.addr = a;
    e.err = err; e.rq = rq; e.t = $time;
    sbq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_cmp(input logic lk, input logic [15:0] a, input logic [3:0] c,
                        input logic err, input string rq);
    cmp_valid = 1'b1; cmp_lock = lk; cmp_addr = a; cmp_ctx = c;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_lock = 1'b0;
    chk(rq, "miss_err after completion", miss_err, err);
  endtask

  task automatic do_ev(input logic [1:0] k, input logic [15:0] a, input logic [1:0] w);
    ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_way = w;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // ---------------- monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (sbq.size() == 0) begin
          chk("R2", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.rq, "latency", $time - e.t, 10);
          chk(e.rq, "status", resp_status, e.stat);
          chk(e.rq, "issue", iss_valid, e.iss);
          if (e.iss) begin
            chk(e.rq, "iss_type", iss_type, e.ityp);
            chk(e.rq, "iss_addr", iss_addr, e.addr);
          end
          chk(e.rq, "miss_err", miss_err, e.err);
        end
      end else if (sbq.size() > 0 && sbq[0].t < $time) begin
        chk("R2", "missing response", 0, 1);
        void'(sbq.pop_front());
      end
    end
  end

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  // ---------------- stimulus
  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_kind = 0; req_addr = 0; req_len = 0; req_ctx = 0;
    cmp_valid = 0; cmp_lock = 0; cmp_addr = 0; cmp_ctx = 0;
    ev_valid = 0; ev_kind = EK_NOP; ev_addr = 0; ev_way = 0;
    repeat (3) @(negedge clk);
    chk("R1", "resp_valid in reset", resp_valid, 0);
    chk("R1", "iss_valid in reset", iss_valid, 0);
    chk("R1", "miss_err in reset", miss_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs idle after reset", {resp_valid, iss_valid, miss_err}, 0);

    do_ev(EK_ALLOC, LA, 2'd0);
    do_ev(EK_ALLOC, LB, 2'd1);
    do_ev(EK_ALLOC, LC, 2'd2);

    // R1: no owner after reset
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_SCFAIL, 1'b0, "R1");

    // R8 / R9: loads untracked, never busy
    do_req(RK_LOAD, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R8");
    do_req(RK_LOAD, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R9");

    // R3: locked read reserves on completion
    do_req(RK_LREAD, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R3");
    do_req(RK_LOAD, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R9");
    do_cmp(1'b1, LA, 4'd3, 1'b0, "R3");

    // R5: foreign context fails, owner keeps its reservation
    do_req(RK_LWRITE, LA, 7'd4, 4'd5, RS_SCFAIL, 1'b0, "R5");
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R5");
    do_cmp(1'b0, LA, 4'd3, 1'b0, "R4");
    // R4: success dropped the reservation
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_SCFAIL, 1'b0, "R4");

    // R6: allocate wipes the way
    do_cmp(1'b1, LB, 4'd7, 1'b0, "R6");
    do_ev(EK_ALLOC, LB, 2'd1);
    do_req(RK_LWRITE, LB, 7'd4, 4'd7, RS_SCFAIL, 1'b0, "R6");

    // R7: permission change wipes, with a positive control
    do_cmp(1'b1, LB, 4'd7, 1'b0, "R7");
    do_ev(EK_PERM, LB, 2'd0);
    do_req(RK_LWRITE, LB, 7'd4, 4'd7, RS_SCFAIL, 1'b0, "R7");
    do_cmp(1'b1, LB, 4'd7, 1'b0, "R7");
    do_req(RK_LWRITE, LB, 7'd4, 4'd7, RS_DONE, 1'b0, "R7");
    do_cmp(1'b0, LB, 4'd7, 1'b0, "R7");

    // R7 / R11: deallocate removes the line
    do_cmp(1'b1, LC, 4'd2, 1'b0, "R7");
    do_ev(EK_DEALLOC, LC, 2'd0);
    do_req(RK_LWRITE, LC, 7'd4, 4'd2, RS_SCFAIL, 1'b1, "R11");
    do_ev(EK_ALLOC, LC, 2'd2);
    do_req(RK_LWRITE, LC, 7'd4, 4'd2, RS_SCFAIL, 1'b0, "R7");

    // R8 / R9: read-modify-write mapping and per-line blocking
    do_req(RK_RMWR, LA, 7'd4, 4'd1, RS_DONE, 1'b0, "R8");
    do_req(RK_RMWW, LA, 7'd4, 4'd1, RS_BUSY, 1'b0, "R9");
    do_cmp(1'b0, LA, 4'd1, 1'b0, "R9");
    do_req(RK_RMWW, LA, 7'd4, 4'd1, RS_DONE, 1'b0, "R8");
    do_cmp(1'b0, LA, 4'd1, 1'b0, "R9");
    do_req(RK_STORE, LA, 7'd4, 4'd1, RS_DONE, 1'b0, "R8");
    do_cmp(1'b0, LA, 4'd1, 1'b0, "R9");

    // R9: capacity
    for (int i = 1; i <= 4; i++)
      do_req(RK_STORE, 16'(i * 16'h1000), 7'd4, 4'd0, RS_DONE, 1'b0, "R9");
    do_req(RK_STORE, 16'h5000, 7'd4, 4'd0, RS_BUSY, 1'b0, "R9");
    do_req(RK_LOAD, 16'h5000, 7'd4, 4'd0, RS_DONE, 1'b0, "R9");
    do_cmp(1'b0, 16'h1000, 4'd0, 1'b0, "R9");
    do_req(RK_STORE, 16'h5000, 7'd4, 4'd0, RS_DONE, 1'b0, "R9");
    for (int i = 2; i <= 5; i++)
      do_cmp(1'b0, 16'(i * 16'h1000), 4'd0, 1'b0, "R9");

    // R10: line-crossing checks
    do_req(RK_STORE, LA + 16'd60, 7'd4, 4'd0, RS_DONE, 1'b0, "R10");
    do_cmp(1'b0, LA, 4'd0, 1'b0, "R10");
    do_req(RK_STORE, LA + 16'd60, 7'd5, 4'd0, RS_SPAN, 1'b0, "R10");
    do_req(RK_STORE, LA, 7'd4, 4'd0, RS_DONE, 1'b0, "R10");
    do_cmp(1'b0, LA, 4'd0, 1'b0, "R10");
    do_cmp(1'b1, LA, 4'd3, 1'b0, "R10");
    do_req(RK_LWRITE, LA + 16'd62, 7'd4, 4'd3, RS_SPAN, 1'b0, "R10");
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R10");
    do_cmp(1'b0, LA, 4'd3, 1'b0, "R10");

    // R11: operations on an absent line
    do_cmp(1'b1, LX, 4'd3, 1'b1, "R11");
    do_req(RK_LWRITE, LX, 7'd4, 4'd3, RS_SCFAIL, 1'b1, "R11");

    // R12: same-cycle allocate and reserve on one way
    ev_valid = 1'b1; ev_kind = EK_ALLOC; ev_addr = LA; ev_way = 2'd0;
    cmp_valid = 1'b1; cmp_lock = 1'b1; cmp_addr = LA; cmp_ctx = 4'd3;
    @(negedge clk);
    ev_valid = 1'b0; cmp_valid = 1'b0; cmp_lock = 1'b0;
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_SCFAIL, 1'b0, "R12");
    do_cmp(1'b1, LA, 4'd3, 1'b0, "R12");
    do_req(RK_LWRITE, LA, 7'd4, 4'd3, RS_DONE, 1'b0, "R12");
    do_cmp(1'b0, LA, 4'd3, 1'b0, "R12");

    repeat (3) @(negedge clk);
    chk("R2", "no stray strobe at end", resp_valid, 0);
    finish_run();
  end

endmodule